// File: doc/BRIEF.md
# Tagless Loop Buffer Controller

This block runs a small direct-mapped instruction buffer placed between the fetch stage and the main instruction cache. The buffer keeps no address tags. The controller watches the executed instruction stream for a taken PC-relative branch that jumps back by only a few instructions. The size of that jump fixes the loop length, which is loaded into a small up-counter. While the loop body runs the first time, words returned by the main cache are written into the buffer at the index given by the low PC bits. When the closing branch is taken again, the controller knows that every later fetch of the loop body is held in the buffer.

From then on the fetch stage reads `hit_next` before it issues a request. While `hit_next` is high, each `fetch_req` is answered one cycle later from the buffer. The fetch pointer walks from the loop head to the closing branch and wraps back to the head without a gap. The response that carries the closing branch is flagged as folded and predicted taken. Three events return the controller to idle and stop buffer supply: the closing branch falling through, any other taken branch inside the body, and an interrupt.

Program counters and displacements are counted in instruction words. Only the low PC bits that index the buffer enter the block.

Top module: `loop_buf_ctrl`

## Requirements
- R1: After synchronous reset, `hit_next` and `rsp_valid` are 0 and `rsp_fold` is 0.
- R2: A loop is detected only from an executed instruction with `ex_valid`=1, `ex_is_branch`=1 and `ex_taken`=1 whose two's-complement `ex_disp` lies in -(2^CW-1)..-1. A zero or positive displacement, a displacement below -(2^CW-1), a branch that is not taken, or an instruction that is not a branch starts nothing: a following loop body plus taken branch leaves `hit_next` at 0.
- R3: After detection with displacement -N, the controller counts N executed non-branch instructions. The next executed instruction is the closing branch. If it is taken, `hit_next` is 1 after that clock edge, and it stays 0 throughout the first pass. Each later taken closing branch keeps `hit_next` at 1.
- R4: While `hit_next` is 1, a `fetch_req` sampled at an edge gives `rsp_valid`=1 after that edge. `rsp_instr` equals the word filled at index (head PC + j mod (N+1)) mod 2^CW for the j-th request, where the head PC is the closing PC minus N. Requests with no gap wrap from the closing branch to the head.
- R5: `rsp_fold` is 1 exactly on the responses that carry the closing branch (j mod (N+1) = N), and 0 on all others.
- R6: If the instruction executed in the closing slot is not a taken branch (a fall-through or a non-branch), `hit_next` is 0 after that edge.
- R7: A taken branch executed before the closing slot returns the controller to idle: `hit_next` is 0 after that edge.
- R8: `ex_irq`=1 at an edge returns the controller to idle whatever else is presented: `hit_next` is 0 after that edge.
- R9: Buffer words are written from `fill_valid`/`fill_pc_lo`/`fill_data` only between detection and the first taken closing branch. Fill traffic while the buffer supplies fetches leaves the stored words unchanged.
- R10: While `hit_next` is 0, a `fetch_req` gives `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | One instruction executed in sequence this cycle |
| ex_is_branch | input | 1 | The executed instruction is a PC-relative branch |
| ex_taken | input | 1 | The executed branch was taken |
| ex_disp | input | DW | Signed branch displacement in instruction words |
| ex_pc_lo | input | CW | Low PC bits of the executed instruction |
| ex_irq | input | 1 | Interrupt taken this cycle |
| fill_valid | input | 1 | Main cache returns a word for a fetch |
| fill_pc_lo | input | CW | Low PC bits of the returned word |
| fill_data | input | IW | Returned instruction word |
| fetch_req | input | 1 | Fetch stage requests the next loop instruction |
| hit_next | output | 1 | The next fetch will be served by the buffer |
| rsp_valid | output | 1 | Buffer response valid |
| rsp_instr | output | IW | Instruction word from the buffer |
| rsp_fold | output | 1 | Response is the closing branch, predicted taken |

## Verification
The hardest state to reach from the ports is the buffer supplying a loop whose body wraps across the top of the index range, while fill traffic and executed instructions still arrive. The bench sweeps loop lengths from 1 to the largest the counter allows and places closing PCs so that some bodies cross index 2^CW-1. It runs a full fill pass and then fetches more than two laps, so that every wrap and fold position is seen. It then writes foreign fill data during supply and fetches another full lap to show that the stored words survive. Each case then leaves through a different exit (interrupt, inner taken branch, fall-through, non-branch in the closing slot).

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    LB_IDLE   = 2'd0,
    LB_FILL   = 2'd1,
    LB_SUPPLY = 2'd2
  } lb_mode_e;
endpackage

// File: rtl/lb_sbb_detect.sv
module lb_sbb_detect #(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          is_branch,
  input  logic          taken,
  input  logic [DW-1:0] disp,
  output logic          short_back
);
  localparam logic [DW-1:0] D_ONE = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] MAXN  = DW'((2**CW) - 1);

  logic [DW-1:0] mag;

  always_comb begin
    mag        = (~disp) + D_ONE;
    short_back = is_branch && taken && disp[DW-1] && (mag <= MAXN);
  end
endmodule

// File: rtl/lb_seq.sv
module lb_seq
  import lb_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ex_valid,
  input  logic          ex_is_branch,
  input  logic          ex_taken,
  input  logic [DW-1:0] ex_disp,
  input  logic [CW-1:0] ex_pc_lo,
  input  logic          ex_irq,
  input  logic          short_back,
  output lb_mode_e      mode,
  output logic [CW-1:0] loop_ld,
  output logic [CW-1:0] head_idx,
  output logic          enter_supply
);
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt;
  logic          br_taken;
  logic          in_loop;

  always_comb begin
    br_taken     = ex_is_branch && ex_taken;
    in_loop      = (mode == LB_FILL) || (mode == LB_SUPPLY);
    enter_supply = ex_valid && !ex_irq && (mode == LB_FILL) &&
                   (cnt == '0) && br_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= LB_IDLE;
      cnt      <= '0;
      loop_ld  <= '0;
      head_idx <= '0;
    end else if (ex_irq) begin
      mode <= LB_IDLE;
    end else if (ex_valid) begin
      if (mode == LB_IDLE) begin
        if (short_back) begin
          mode     <= LB_FILL;
          cnt      <= ex_disp[CW-1:0];
          loop_ld  <= ex_disp[CW-1:0];
          head_idx <= ex_pc_lo + ex_disp[CW-1:0];
        end
      end else if (cnt == '0) begin
        if (br_taken) begin
          mode <= LB_SUPPLY;
          cnt  <= loop_ld;
        end else begin
          mode <= LB_IDLE;
        end
      end else if (br_taken) begin
        mode <= LB_IDLE;
      end else begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  // R3: a sequential body instruction advances the loop count by one
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    (in_loop && ex_valid && !ex_irq && (cnt != '0) && !br_taken)
      |=> (cnt == $past(cnt) + CNT_ONE));

  // R8: an interrupt always leaves the controller idle
  p_irq_idle_r8: assert property (@(posedge clk) disable iff (rst)
    ex_irq |=> (mode == LB_IDLE));
endmodule

// File: rtl/lb_ram.sv
module lb_ram #(
  parameter int DEPTH = 32,
  parameter int IW    = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [IW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [IW-1:0]            rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lb_fetch.sv
module lb_fetch #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply,
  input  logic          enter_supply,
  input  logic [CW-1:0] loop_ld,
  input  logic [CW-1:0] head_idx,
  input  logic          fetch_req,
  output logic          rd_en,
  output logic [CW-1:0] rd_idx,
  output logic          rsp_valid,
  output logic          rsp_fold
);
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] f_idx;
  logic [CW-1:0] f_cnt;

  always_comb begin
    rd_en  = fetch_req && supply;
    rd_idx = f_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_idx     <= '0;
      f_cnt     <= '0;
      rsp_valid <= 1'b0;
      rsp_fold  <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      rsp_fold  <= rd_en && (f_cnt == '0);
      if (enter_supply) begin
        f_idx <= head_idx;
        f_cnt <= loop_ld;
      end else if (rd_en) begin
        if (f_cnt == '0) begin
          f_idx <= head_idx;
          f_cnt <= loop_ld;
        end else begin
          f_idx <= f_idx + CNT_ONE;
          f_cnt <= f_cnt + CNT_ONE;
        end
      end
    end
  end

  // R5: after a folded response the pointer is back at the loop head
  p_fold_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_fold |-> (f_idx == head_idx));

  // R5: a fold is always a valid response
  p_fold_valid_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_fold |-> rsp_valid);
endmodule

// File: rtl/loop_buf_ctrl.sv
module loop_buf_ctrl
  import lb_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 5,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ex_valid,
  input  logic          ex_is_branch,
  input  logic          ex_taken,
  input  logic [DW-1:0] ex_disp,
  input  logic [CW-1:0] ex_pc_lo,
  input  logic          ex_irq,
  input  logic          fill_valid,
  input  logic [CW-1:0] fill_pc_lo,
  input  logic [IW-1:0] fill_data,
  input  logic          fetch_req,
  output logic          hit_next,
  output logic          rsp_valid,
  output logic [IW-1:0] rsp_instr,
  output logic          rsp_fold
);
  localparam int DEPTH = 2**CW;

  lb_mode_e      mode;
  logic          short_back;
  logic [CW-1:0] loop_ld;
  logic [CW-1:0] head_idx;
  logic          enter_supply;
  logic          rd_en;
  logic [CW-1:0] rd_idx;
  logic          wr_en;

  lb_sbb_detect #(.DW(DW), .CW(CW)) u_det (
    .is_branch (ex_is_branch),
    .taken     (ex_taken),
    .disp      (ex_disp),
    .short_back(short_back)
  );

  lb_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ex_valid    (ex_valid),
    .ex_is_branch(ex_is_branch),
    .ex_taken    (ex_taken),
    .ex_disp     (ex_disp),
    .ex_pc_lo    (ex_pc_lo),
    .ex_irq      (ex_irq),
    .short_back  (short_back),
    .mode        (mode),
    .loop_ld     (loop_ld),
    .head_idx    (head_idx),
    .enter_supply(enter_supply)
  );

  assign hit_next = (mode == LB_SUPPLY);
  assign wr_en    = fill_valid && (mode == LB_FILL);

  lb_fetch #(.CW(CW)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .supply      (hit_next),
    .enter_supply(enter_supply),
    .loop_ld     (loop_ld),
    .head_idx    (head_idx),
    .fetch_req   (fetch_req),
    .rd_en       (rd_en),
    .rd_idx      (rd_idx),
    .rsp_valid   (rsp_valid),
    .rsp_fold    (rsp_fold)
  );

  lb_ram #(.DEPTH(DEPTH), .IW(IW)) u_ram (
    .clk  (clk),
    .we   (wr_en),
    .waddr(fill_pc_lo),
    .wdata(fill_data),
    .re   (rd_en),
    .raddr(rd_idx),
    .rdata(rsp_instr)
  );

  // R10: a response only follows a request made while supplying
  p_rsp_only_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(fetch_req && hit_next));

  // R3: supply starts only on a taken branch
  p_rise_on_taken_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_next) |-> $past(ex_valid && ex_is_branch && ex_taken && !ex_irq));

  // R8: interrupt stops supply
  p_irq_exit_r8: assert property (@(posedge clk) disable iff (rst)
    ex_irq |=> !hit_next);

  // R9: no buffer write while supplying
  p_no_write_supply_r9: assert property (@(posedge clk) disable iff (rst)
    hit_next |-> !wr_en);
endmodule

// File: tb/tb_loop_buf_ctrl.sv
module tb_loop_buf_ctrl;
  localparam int DW = 8;
  localparam int CW = 5;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ex_valid = 0, ex_is_branch = 0, ex_taken = 0, ex_irq = 0;
  logic [DW-1:0] ex_disp = '0;
  logic [CW-1:0] ex_pc_lo = '0;
  logic          fill_valid = 0;
  logic [CW-1:0] fill_pc_lo = '0;
  logic [IW-1:0] fill_data = '0;
  logic          fetch_req = 0;
  logic          hit_next, rsp_valid, rsp_fold;
  logic [IW-1:0] rsp_instr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  loop_buf_ctrl #(.DW(DW), .CW(CW), .IW(IW)) dut (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_is_branch(ex_is_branch),
    .ex_taken(ex_taken), .ex_disp(ex_disp), .ex_pc_lo(ex_pc_lo), .ex_irq(ex_irq),
    .fill_valid(fill_valid), .fill_pc_lo(fill_pc_lo), .fill_data(fill_data),
    .fetch_req(fetch_req), .hit_next(hit_next), .rsp_valid(rsp_valid),
    .rsp_instr(rsp_instr), .rsp_fold(rsp_fold)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [IW-1:0] fd(input int pc, input int salt);
    return IW'(pc * 37 + salt * 101 + 5);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear();
    ex_valid = 0; ex_is_branch = 0; ex_taken = 0; ex_irq = 0;
    ex_disp = '0; fill_valid = 0; fetch_req = 0;
  endtask

  task automatic exec(input int pc, input bit br, input bit tk, input int disp);
    ex_valid = 1; ex_is_branch = br; ex_taken = tk;
    ex_disp = DW'(disp); ex_pc_lo = CW'(pc);
    tick();
    clear();
  endtask

  task automatic body(input int head, input int n);
    for (int k = 0; k < n; k++) exec(head + k, 0, 0, 0);
  endtask

  task automatic fetch_laps(input int head, input int n, input int start,
                            input int cnt, input int salt);
    for (int j = 0; j < cnt; j++) begin
      int pos;
      pos = (start + j) % (n + 1);
      fetch_req = 1;
      tick();
      check("R4 rsp_valid", rsp_valid, 1);
      check("R4 rsp_instr", rsp_instr, fd(head + pos, salt));
      check("R5 rsp_fold", rsp_fold, (pos == n) ? 1 : 0);
    end
    fetch_req = 0;
  endtask

  task automatic run_case(input int n, input int p, input int exitk, input int salt);
    int head;
    int m;
    head = p - n;
    exec(p, 1, 1, -n);
    check("R2 detect leaves hit_next low", hit_next, 0);
    for (int k = 0; k < n; k++) begin
      fill_valid = 1; fill_pc_lo = CW'(head + k); fill_data = fd(head + k, salt);
      exec(head + k, 0, 0, 0);
    end
    fill_valid = 1; fill_pc_lo = CW'(p); fill_data = fd(p, salt);
    tick();
    clear();
    check("R3 no supply in first pass", hit_next, 0);
    exec(p, 1, 1, -n);
    check("R3 supply after closing branch", hit_next, 1);
    m = 2 * (n + 1) + 1;
    fetch_laps(head, n, 0, m, salt);
    // R9: foreign fill while supplying must not overwrite
    fill_valid = 1; fill_pc_lo = CW'(head); fill_data = ~fd(head, salt);
    tick();
    clear();
    fetch_laps(head, n, m % (n + 1), n + 1, salt);
    check("R9 hit_next after foreign fill", hit_next, 1);
    body(head, n);
    exec(p, 1, 1, -n);
    check("R3 supply kept over iteration", hit_next, 1);
    case (exitk)
      0: begin
        ex_irq = 1; tick(); clear();
        check("R8 irq exit", hit_next, 0);
      end
      1: begin
        exec(head, 1, 1, 3);
        check("R7 inner taken branch exit", hit_next, 0);
      end
      2: begin
        body(head, n);
        check("R6 still supplying before exit", hit_next, 1);
        exec(p, 1, 0, -n);
        check("R6 fall-through exit", hit_next, 0);
      end
      default: begin
        body(head, n);
        exec(p, 0, 0, 0);
        check("R6 non-branch in closing slot exit", hit_next, 0);
      end
    endcase
    fetch_req = 1;
    tick();
    fetch_req = 0;
    check("R10 no response when idle", rsp_valid, 0);
  endtask

  task automatic neg_case(input int disp, input bit br, input bit tk, input string what);
    exec(10, br, tk, disp);
    body(11, 5);
    exec(16, 1, 1, -5);
    check(what, hit_next, 0);
    ex_irq = 1; tick(); clear();
  endtask

  initial begin
    clear();
    rst = 1;
    repeat (3) tick();
    check("R1 hit_next reset", hit_next, 0);
    check("R1 rsp_valid reset", rsp_valid, 0);
    check("R1 rsp_fold reset", rsp_fold, 0);
    rst = 0;
    tick();
    fetch_req = 1; tick(); fetch_req = 0;
    check("R10 no response after reset", rsp_valid, 0);

    neg_case(0,   1, 1, "R2 zero displacement ignored");
    neg_case(4,   1, 1, "R2 forward displacement ignored");
    neg_case(-32, 1, 1, "R2 too long displacement ignored");
    neg_case(-5,  1, 0, "R2 not taken ignored");
    neg_case(-5,  0, 1, "R2 non-branch ignored");

    run_case(1,  100, 0, 1);
    run_case(2,  33,  1, 2);
    run_case(5,  7,   2, 3);
    run_case(16, 40,  3, 4);
    run_case(31, 31,  0, 5);
    run_case(31, 200, 1, 6);
    run_case(3,  1,   2, 7);
    run_case(9,  60,  3, 8);
    run_case(4,  34,  0, 9);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule